// File: doc/BRIEF.md
# Linear Sensor Readout Sequencer

This block is the digital sequencer that runs the readout of a 32-pixel linear light sensor. A readout clock steps through the array. A start strobe, sampled on the rising clock edge, begins a readout and, with it, the next integration period. The block drives a pixel select for the analog output multiplexer. It also drives two sample/hold controls, one shared by pixels 1 to 31 and one for pixel 32 alone, and an active-low discharge pulse for the integration capacitors.

Pixel 32's hold control trails the shared one by one clock. Because of this, all 32 pixels can be read in 32 clock pulses. The discharge pulse lasts one full clock period and runs between falling edges. It comes from a register clocked on the negative edge that samples a rising-edge flag, so it has no glitches. A strobe that arrives while pixels 1 to 31 are being shown restarts the scan at pixel 1 and leaves the hold state unchanged. When the scan completes and no new strobe arrives, the block rests on pixel 1 in sample mode.

The sequencer has three states:
- `ST_IDLE`: rest on pixel 1.
- `ST_SCAN`: pixels 1 to 31.
- `ST_FINAL`: pixel 32.

It has five transitions:
- *launch*: `ST_IDLE` or `ST_FINAL` to `ST_SCAN` on a strobe.
- *restart*: `ST_SCAN` to `ST_SCAN` at pixel 1 on a strobe.
- *advance*: `ST_SCAN` to `ST_SCAN` at the next pixel.
- *reach_last*: `ST_SCAN` to `ST_FINAL` after pixel 31.
- *finish*: `ST_FINAL` to `ST_IDLE` with no strobe.

Top module: `lsr_seq_top`

## Requirements
- R1: While reset is asserted, the pixel select is 0, both hold controls are 0, busy is 0 and the discharge output is 0 (capacitors discharged).
- R2: A strobe at a rising edge in `ST_IDLE` launches a readout. After that edge the select is 0 (pixel 1), the shared hold is 1 and busy is 1.
- R3: The select code equals pixel number minus 1 and increments by one at each rising edge without a strobe. Pixel 32 (code 31) is therefore shown after the 32nd edge of a readout.
- R4: The pixel-32 hold control equals the shared hold control delayed by one clock, for both its set and its clear.
- R5: The shared hold control returns to 0 at the edge where code 31 becomes selected.
- R6: After a launch edge, the discharge output is low for exactly one clock period, from the 2nd to the 3rd falling edge after that launch. A restart does not produce another discharge pulse.
- R7: A strobe while codes 0 to 30 are selected restarts the scan at code 0. The shared hold stays at 1 and no new discharge pulse follows.
- R8: A strobe while code 31 is selected is a launch: a new readout starts with a new discharge pulse.
- R9: One edge after code 31, with no strobe, the block idles: the select stays 0 and the shared hold and busy stay 0 until the next strobe.
- R10: Busy is 1 from the launch edge through the cycle in which code 31 is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| start_i | input | 1 | Start strobe, sampled on the rising edge |
| pix_sel_o | output | 5 | Output multiplexer select, pixel number minus 1 |
| hold_main_o | output | 1 | Sample/hold control for pixels 1 to 31 (1 = hold) |
| hold_last_o | output | 1 | Sample/hold control for pixel 32 (1 = hold) |
| integ_rst_n_o | output | 1 | Active-low integration capacitor discharge |
| busy_o | output | 1 | Readout in progress |

## Verification
The assertions assume that the strobe is a synchronous level, stable around each rising edge. They also assume that reset is released away from a clock edge, so that every check starts from a known state. The bench changes the strobe only at falling edges and releases reset just after a falling edge. The bench applies a launch strobe to every restart position and places strobes on pixel 32 and in idle. It compares every output after every rising edge with a model that applies the requirements directly.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_FINAL = 2'd2
    } seq_state_e;
endpackage

// File: rtl/lsr_scan_fsm.sv
module lsr_scan_fsm
    import lsr_pkg::*;
#(
    parameter int NPIX = 32,
    localparam int IW = $clog2(NPIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output seq_state_e    state_o,
    output logic [IW-1:0] idx_o,
    output logic          launch_o,
    output logic          to_final_o
);
    localparam logic [IW-1:0] IDX_LAST = IW'(NPIX - 1);

    seq_state_e    state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;

    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        launch_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idx_d = '0;
                if (start_i) begin
                    state_d  = ST_SCAN;
                    launch_o = 1'b1;
                end
            end
            ST_SCAN: begin
                if (start_i) begin
                    idx_d = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                    if (idx_d == IDX_LAST) state_d = ST_FINAL;
                end
            end
            ST_FINAL: begin
                idx_d = '0;
                if (start_i) begin
                    state_d  = ST_SCAN;
                    launch_o = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    assign to_final_o = (state_d == ST_FINAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;

    assert_idle_rest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (idx_q == '0));
    assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && !start_i) |=> (idx_q == $past(idx_q) + 1'b1));
    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && start_i) |=> (idx_q == '0 && state_q == ST_SCAN));
    assert_final_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINAL) |-> (idx_q == IDX_LAST));
endmodule

// File: rtl/lsr_ctrl.sv
module lsr_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    input  logic to_final_i,
    output logic hold_main_o,
    output logic hold_last_o,
    output logic integ_rst_n_o
);
    logic hold_main_q, hold_last_q;
    logic fresh_q, pend_q;
    logic integ_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_main_q <= 1'b0;
            hold_last_q <= 1'b0;
            fresh_q     <= 1'b0;
            pend_q      <= 1'b0;
        end else begin
            if (launch_i)        hold_main_q <= 1'b1;
            else if (to_final_i) hold_main_q <= 1'b0;
            hold_last_q <= hold_main_q;
            fresh_q     <= launch_i;
            pend_q      <= fresh_q;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) integ_n_q <= 1'b0;
        else        integ_n_q <= ~pend_q;
    end

    assign hold_main_o   = hold_main_q;
    assign hold_last_o   = hold_last_q;
    assign integ_rst_n_o = integ_n_q;

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!integ_n_q && $past(integ_n_q)) |=> integ_n_q);
    assert_hold_on_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |=> hold_main_q);
    assert_hold_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (to_final_i && !launch_i) |=> !hold_main_q);
endmodule

// File: rtl/lsr_seq_top.sv
module lsr_seq_top
    import lsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    output logic [4:0] pix_sel_o,
    output logic       hold_main_o,
    output logic       hold_last_o,
    output logic       integ_rst_n_o,
    output logic       busy_o
);
    localparam int NPIX = 32;

    seq_state_e state;
    logic [4:0] idx;
    logic       launch, to_final;

    lsr_scan_fsm #(.NPIX(NPIX)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .state_o    (state),
        .idx_o      (idx),
        .launch_o   (launch),
        .to_final_o (to_final)
    );

    lsr_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .launch_i      (launch),
        .to_final_i    (to_final),
        .hold_main_o   (hold_main_o),
        .hold_last_o   (hold_last_o),
        .integ_rst_n_o (integ_rst_n_o)
    );

    assign pix_sel_o = idx;
    assign busy_o    = (state != ST_IDLE);

    assert_idle_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (pix_sel_o == 5'd0 && !hold_main_o));
    assert_busy_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
    assert_last_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && pix_sel_o == 5'd31) |-> !hold_main_o);
endmodule

// File: tb/lsr_seq_top_test.sv
module lsr_seq_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [4:0] pix_sel_o;
    logic       hold_main_o, hold_last_o, integ_rst_n_o, busy_o;

    int n_vec = 0;
    int n_bad = 0;

    // reference state
    bit    m_act = 0;
    int    m_idx = 0;
    bit    m_hold = 0;
    bit    m_holdl = 0;
    int    m_since = 100;
    string m_tag = "R1";

    always #4 clk = ~clk; // 125 MHz

    lsr_seq_top uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .pix_sel_o(pix_sel_o), .hold_main_o(hold_main_o), .hold_last_o(hold_last_o),
        .integ_rst_n_o(integ_rst_n_o), .busy_o(busy_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_edge(input bit s);
        bit old_hold = m_hold;
        if (s && (!m_act || m_idx == 31)) begin
            m_tag   = m_act ? "R8" : "R2";
            m_act   = 1; m_idx = 0; m_hold = 1; m_since = 0;
        end else if (s && m_act) begin
            m_tag = "R7"; m_idx = 0;
            if (m_since < 100) m_since++;
        end else begin
            if (m_act) begin
                if (m_idx == 31) begin
                    m_act = 0; m_idx = 0; m_tag = "R9";
                end else begin
                    m_idx++; m_tag = "R3";
                    if (m_idx == 31) m_hold = 0;
                end
            end else m_tag = "R9";
            if (m_since < 100) m_since++;
        end
        m_holdl = old_hold;
    endtask

    task automatic step(input bit s);
        @(negedge clk);
        start_i = s;
        @(posedge clk);
        model_edge(s);
        #2;
        chk(m_tag, "pix_sel", int'(pix_sel_o), m_idx);
        chk("R5", "hold_main", int'(hold_main_o), int'(m_hold));
        chk("R4", "hold_last", int'(hold_last_o), int'(m_holdl));
        chk("R6", "integ_rst_n", int'(integ_rst_n_o), (m_since == 2) ? 0 : 1);
        chk("R10", "busy", int'(busy_o), int'(m_act));
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        #19;
        chk("R1", "pix_sel", int'(pix_sel_o), 0);
        chk("R1", "hold_main", int'(hold_main_o), 0);
        chk("R1", "hold_last", int'(hold_last_o), 0);
        chk("R1", "integ_rst_n", int'(integ_rst_n_o), 0);
        chk("R1", "busy", int'(busy_o), 0);
        @(negedge clk); #1 rst_n = 1'b1;

        // R9: idle with no strobe
        for (int i = 0; i < 3; i++) step(0);
        // R2, R3, R6, R9: full readout then idle overrun
        step(1);
        for (int i = 0; i < 40; i++) step(0);
        // R7: restart at every position 1..31 after launch
        for (int p = 1; p < 32; p++) begin
            step(1);
            for (int i = 1; i < p; i++) step(0);
            step(1);
            for (int i = 0; i < 36; i++) step(0);
        end
        // R8: strobe while pixel 32 shown, twice in a row
        step(1);
        for (int i = 0; i < 31; i++) step(0);
        step(1);
        for (int i = 0; i < 31; i++) step(0);
        step(1);
        for (int i = 0; i < 40; i++) step(0);
        // strobe held high: repeated restarts, then release
        for (int i = 0; i < 40; i++) step(1);
        for (int i = 0; i < 36; i++) step(0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule